// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block turns a 32-bit single-register memory transfer instruction into the values a load/store pipeline stage needs. From the instruction word, the base register value and the offset register value it computes the effective memory address, the access size, whether the loaded value is sign-extended, whether the access is a load or a store, and whether and with what value the base register is written back. A side input selects which of two instruction formats is decoded: the word/unsigned-byte format or the halfword/signed format.

The decoded results are registered one cycle after an instruction is presented with `in_valid`. While those results are held, the block also formats the 32-bit word returned by memory into the final 32-bit load value: it picks the byte or halfword lane from the low address bits in little-endian order and zero- or sign-extends it. Condition evaluation, register file access and the memory itself sit outside the block.

Top module: `lsu_agu`

## Requirements
- R1: During and after a synchronous active-high reset with no instruction presented, `out_valid`, `wb_en`, `is_load` and `mem_addr` are all zero.
- R2: In the word/byte format (`fmt_hs`=0) with bit 25 clear, the offset is the zero-extended 12-bit field in bits [11:0]; bit 23 set adds it to the base, bit 23 clear subtracts it.
- R3: In the word/byte format with bit 25 set, the offset is `rm_val` shifted by the 5-bit amount in bits [11:7] with the type in bits [6:5]: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right; an amount of 0 yields `rm_val` unchanged for every type.
- R4: With bit 24 set (pre-indexed), `mem_addr` is base plus/minus offset, `wb_en` equals bit 21, and `wb_val` equals `mem_addr`.
- R5: With bit 24 clear (post-indexed), `mem_addr` is the unmodified base, `wb_en` is 1 regardless of bit 21, and `wb_val` is base plus/minus offset.
- R6: In the halfword/signed format (`fmt_hs`=1), bit 22 set selects an 8-bit immediate whose upper nibble is bits [11:8] and lower nibble bits [3:0]; bit 22 clear selects `rm_val` unshifted, bits [11:8] having no effect.
- R7: `acc_size` encodes 0 = byte, 1 = halfword, 2 = word. In the word/byte format bit 22 set gives byte and clear gives word, never signed. In the halfword/signed format bits [6:5] give 01 unsigned halfword, 10 signed byte, 11 signed halfword, 00 unsigned halfword; `sign_ext` is set only for the signed kinds when the access is a load.
- R8: `is_load` equals instruction bit 20.
- R9: `ld_data` takes the byte lane `mem_addr[1:0]` or halfword lane `mem_addr[1]` of `rd_data` (lane 0 in the least significant bits), zero-extended when `sign_ext` is 0 and sign-extended when 1; a word access passes `rd_data` unchanged.
- R10: Outputs update at the first rising edge after `in_valid` is sampled high; when `in_valid` is low, `out_valid` goes to 0 on the next edge and the other registered outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| fmt_hs | input | 1 | 1 = halfword/signed format, 0 = word/byte format |
| base_val | input | 32 | Base register value |
| rm_val | input | 32 | Offset register value |
| rd_data | input | 32 | Word read from memory for the held access |
| out_valid | output | 1 | Registered results are from an instruction |
| mem_addr | output | 32 | Effective memory address |
| acc_size | output | 2 | Access size code |
| sign_ext | output | 1 | Load result is sign-extended |
| is_load | output | 1 | 1 = load, 0 = store |
| wb_en | output | 1 | Base register write-back enable |
| wb_val | output | 32 | New base register value |
| ld_data | output | 32 | Formatted load value |

## Verification
A wrong decode or arithmetic result appears at the ports one edge after the instruction is taken: a misread index bit shows as an address equal to the base when it should be offset (or the reverse), or as a write-back enable that disagrees with bit 21. A wrong shift or offset field selection shows as an address off by the misapplied offset in the same cycle. Lane or extension errors show combinationally on `ld_data` as soon as `rd_data` is applied for the held access, so each is exercised with lanes whose top bit is set.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;

    localparam int XLEN    = 32;
    localparam int SHAMT_W = $clog2(XLEN);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        SHK_LSL = 2'd0,
        SHK_LSR = 2'd1,
        SHK_ASR = 2'd2,
        SHK_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic            pre;
        logic            up;
        logic            wback;
        logic            load;
        acc_size_e       size;
        logic            sign;
        logic [XLEN-1:0] offset;
    } xfer_dec_t;

    function automatic logic [XLEN-1:0] barrel(input logic [XLEN-1:0] v,
                                              input shift_kind_e k,
                                              input logic [SHAMT_W-1:0] n);
        logic [2*XLEN-1:0] dbl;
        logic [XLEN-1:0]   r;
        dbl = {v, v} >> n;
        unique case (k)
            SHK_LSL: r = v << n;
            SHK_LSR: r = v >> n;
            SHK_ASR: r = $unsigned($signed(v) >>> n);
            default: r = dbl[XLEN-1:0];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_agu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [31:0]  instr,
    input  logic         fmt_hs,
    input  logic [W-1:0] rm_val,
    output xfer_dec_t    dec
);
    localparam int IMM12_PAD = W - 12;
    localparam int IMM8_PAD  = W - 8;

    always_comb begin
        dec        = '0;
        dec.pre    = instr[24];
        dec.up     = instr[23];
        dec.wback  = instr[21];
        dec.load   = instr[20];
        if (!fmt_hs) begin
            dec.size = instr[22] ? SZ_BYTE : SZ_WORD;
            dec.sign = 1'b0;
            if (instr[25])
                dec.offset = barrel(rm_val, shift_kind_e'(instr[6:5]), instr[11:7]);
            else
                dec.offset = {{IMM12_PAD{1'b0}}, instr[11:0]};
        end else begin
            unique case (instr[6:5])
                2'b10: begin dec.size = SZ_BYTE; dec.sign = instr[20]; end
                2'b11: begin dec.size = SZ_HALF; dec.sign = instr[20]; end
                default: begin dec.size = SZ_HALF; dec.sign = 1'b0; end
            endcase
            dec.offset = instr[22] ? {{IMM8_PAD{1'b0}}, instr[11:8], instr[3:0]} : rm_val;
        end
    end

    // R7: a store never requests sign extension
    always_comb begin
        if (!instr[20]) a_r7_store_unsigned: assert (dec.sign == 1'b0);
    end

endmodule

// File: rtl/lsu_addr.sv
module lsu_addr
    import lsu_agu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] base_val,
    input  xfer_dec_t    dec,
    output logic [W-1:0] addr,
    output logic         wb_en,
    output logic [W-1:0] wb_val
);
    logic [W-1:0] moved;

    always_comb begin
        moved  = dec.up ? (base_val + dec.offset) : (base_val - dec.offset);
        addr   = dec.pre ? moved : base_val;
        wb_en  = dec.pre ? dec.wback : 1'b1;
        wb_val = moved;
    end

endmodule

// File: rtl/lsu_ldfmt.sv
module lsu_ldfmt
    import lsu_agu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] rd_data,
    input  logic [1:0]   lane,
    input  acc_size_e    size,
    input  logic         sign,
    output logic [W-1:0] ld_data
);
    localparam int NBYTE = W / 8;
    localparam int NHALF = W / 16;

    logic [7:0]  bytes [NBYTE];
    logic [15:0] halves[NHALF];

    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        assign bytes[g] = rd_data[8*g +: 8];
    end
    for (genvar g = 0; g < NHALF; g++) begin : g_half
        assign halves[g] = rd_data[16*g +: 16];
    end

    logic [7:0]  bsel;
    logic [15:0] hsel;

    always_comb begin
        bsel = bytes[lane];
        hsel = halves[lane[1]];
        unique case (size)
            SZ_BYTE: ld_data = {{(W-8){sign & bsel[7]}}, bsel};
            SZ_HALF: ld_data = {{(W-16){sign & hsel[15]}}, hsel};
            default: ld_data = rd_data;
        endcase
    end

    // R9: an unsigned byte never carries bits above its lane
    always_comb begin
        if (size == SZ_BYTE && !sign)
            a_r9_byte_zero_ext: assert (ld_data[W-1:8] == '0);
    end

endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
    import lsu_agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic        fmt_hs,
    input  logic [31:0] base_val,
    input  logic [31:0] rm_val,
    input  logic [31:0] rd_data,
    output logic        out_valid,
    output logic [31:0] mem_addr,
    output logic [1:0]  acc_size,
    output logic        sign_ext,
    output logic        is_load,
    output logic        wb_en,
    output logic [31:0] wb_val,
    output logic [31:0] ld_data
);
    localparam int W = XLEN;

    xfer_dec_t    dec;
    logic [W-1:0] addr_c, wbv_c;
    logic         wben_c;
    acc_size_e    size_q;

    lsu_decode #(.W(W)) u_dec (
        .instr (instr),
        .fmt_hs(fmt_hs),
        .rm_val(rm_val),
        .dec   (dec)
    );

    lsu_addr #(.W(W)) u_addr (
        .base_val(base_val),
        .dec     (dec),
        .addr    (addr_c),
        .wb_en   (wben_c),
        .wb_val  (wbv_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            mem_addr  <= '0;
            size_q    <= SZ_BYTE;
            sign_ext  <= 1'b0;
            is_load   <= 1'b0;
            wb_en     <= 1'b0;
            wb_val    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                mem_addr <= addr_c;
                size_q   <= dec.size;
                sign_ext <= dec.sign;
                is_load  <= dec.load;
                wb_en    <= wben_c;
                wb_val   <= wbv_c;
            end
        end
    end

    assign acc_size = size_q;

    lsu_ldfmt #(.W(W)) u_fmt (
        .rd_data(rd_data),
        .lane   (mem_addr[1:0]),
        .size   (size_q),
        .sign   (sign_ext),
        .ld_data(ld_data)
    );

    a_r5_post_base_addr: assert property (@(posedge clk) disable iff (rst)
        in_valid && !instr[24] |=> wb_en && mem_addr == $past(base_val));

    a_r4_pre_wb_follows_w: assert property (@(posedge clk) disable iff (rst)
        in_valid && instr[24] |=> wb_en == $past(instr[21]) && wb_val == mem_addr);

    a_r8_load_bit: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> is_load == $past(instr[20]));

    a_r10_valid_tracks: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(mem_addr) && $stable(wb_val));

endmodule

// File: tb/lsu_agu_bench.sv
module lsu_agu_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic        fmt_hs;
    logic [31:0] base_val;
    logic [31:0] rm_val;
    logic [31:0] rd_data;
    logic        out_valid;
    logic [31:0] mem_addr;
    logic [1:0]  acc_size;
    logic        sign_ext;
    logic        is_load;
    logic        wb_en;
    logic [31:0] wb_val;
    logic [31:0] ld_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lsu_agu u_lsu_agu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .fmt_hs(fmt_hs),
        .base_val(base_val), .rm_val(rm_val), .rd_data(rd_data),
        .out_valid(out_valid), .mem_addr(mem_addr), .acc_size(acc_size),
        .sign_ext(sign_ext), .is_load(is_load), .wb_en(wb_en), .wb_val(wb_val),
        .ld_data(ld_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_w(bit p, bit u, bit b, bit w, bit l, bit i, logic [11:0] off);
        return {4'hE, 2'b01, i, p, u, b, w, l, 4'h3, 4'h4, off};
    endfunction

    function automatic logic [31:0] enc_h(bit p, bit u, bit i, bit w, bit l, bit s, bit h,
                                          logic [3:0] hi, logic [3:0] lo);
        return {4'hE, 3'b000, p, u, i, w, l, 4'h3, 4'h4, hi, 1'b1, s, h, 1'b1, lo};
    endfunction

    // independent reference: shift one bit position at a time
    function automatic logic [31:0] ref_shift(logic [31:0] v, int kind, int n);
        logic [31:0] r = v;
        for (int k = 0; k < n; k++) begin
            case (kind)
                0: r = {r[30:0], 1'b0};
                1: r = {1'b0, r[31:1]};
                2: r = {r[31], r[31:1]};
                default: r = {r[0], r[31:1]};
            endcase
        end
        return r;
    endfunction

    task automatic issue(input logic [31:0] ins, input bit hs, input logic [31:0] b, input logic [31:0] m);
        @(negedge clk);
        instr = ins; fmt_hs = hs; base_val = b; rm_val = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; instr = '0; fmt_hs = 1'b0;
        base_val = '0; rm_val = '0; rd_data = '0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 wb_en", {31'b0, wb_en}, 32'd0);
        check("R1 is_load", {31'b0, is_load}, 32'd0);
        check("R1 mem_addr", mem_addr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_imm_pre();
        // R2 R4 R8: pre-indexed, add, no writeback, load
        issue(enc_w(1, 1, 0, 0, 1, 0, 12'hFFF), 0, 32'h0000_1000, 32'h0);
        check("R10 out_valid", {31'b0, out_valid}, 32'd1);
        check("R2 add imm addr", mem_addr, 32'h0000_1FFF);
        check("R4 no wb when W=0", {31'b0, wb_en}, 32'd0);
        check("R8 load", {31'b0, is_load}, 32'd1);
        check("R7 word size", {30'b0, acc_size}, 32'd2);
        // R2 R4: subtract, writeback, store
        issue(enc_w(1, 0, 1, 1, 0, 0, 12'd12), 0, 32'h0000_0200, 32'h0);
        check("R2 sub imm addr", mem_addr, 32'h0000_01F4);
        check("R4 wb when W=1", {31'b0, wb_en}, 32'd1);
        check("R4 wb_val eq addr", wb_val, 32'h0000_01F4);
        check("R8 store", {31'b0, is_load}, 32'd0);
        check("R7 byte size", {30'b0, acc_size}, 32'd0);
        check("R7 byte never signed", {31'b0, sign_ext}, 32'd0);
    endtask

    task automatic t_shifts();
        logic [31:0] m = 32'h8000_00F1;
        for (int kind = 0; kind < 4; kind++) begin
            for (int n = 0; n < 32; n += 7) begin
                logic [11:0] f = {n[4:0], kind[1:0], 1'b0, 4'h5};
                issue(enc_w(1, 1, 0, 0, 1, 1, f), 0, 32'h0000_4000, m);
                check($sformatf("R3 kind %0d amt %0d", kind, n), mem_addr,
                      32'h0000_4000 + ref_shift(m, kind, n));
            end
        end
    endtask

    task automatic t_post();
        issue(enc_w(0, 1, 0, 0, 1, 0, 12'd12), 0, 32'h0000_0200, 32'h0);
        check("R5 post addr is base", mem_addr, 32'h0000_0200);
        check("R5 post wb despite W=0", {31'b0, wb_en}, 32'd1);
        check("R5 post wb_val", wb_val, 32'h0000_020C);
        issue(enc_w(0, 0, 0, 1, 0, 1, {5'd2, 2'b00, 1'b0, 4'h0}), 0, 32'h0000_0200, 32'd3);
        check("R5 post sub reg addr", mem_addr, 32'h0000_0200);
        check("R5 post sub reg wb_val", wb_val, 32'h0000_01F4);
    endtask

    task automatic t_half();
        // R6 split immediate, signed halfword load
        issue(enc_h(1, 1, 1, 0, 1, 1, 1, 4'hA, 4'h5), 1, 32'h0000_1000, 32'h0);
        check("R6 split imm", mem_addr, 32'h0000_10A5);
        check("R7 signed half size", {30'b0, acc_size}, 32'd1);
        check("R7 signed half sign", {31'b0, sign_ext}, 32'd1);
        // R6 register form: bits [11:8] ignored, no shift
        issue(enc_h(1, 0, 0, 0, 1, 1, 0, 4'hF, 4'h7), 1, 32'h0000_1000, 32'h0000_0010);
        check("R6 reg unshifted", mem_addr, 32'h0000_0FF0);
        check("R7 signed byte size", {30'b0, acc_size}, 32'd0);
        check("R7 signed byte sign", {31'b0, sign_ext}, 32'd1);
        // unsigned halfword
        issue(enc_h(0, 1, 1, 1, 1, 0, 1, 4'h0, 4'h2), 1, 32'h0000_2000, 32'h0);
        check("R7 unsigned half sign", {31'b0, sign_ext}, 32'd0);
        check("R5 half post wb_val", wb_val, 32'h0000_2002);
        // signed kind on a store: no sign request
        issue(enc_h(1, 1, 1, 0, 0, 1, 1, 4'h0, 4'h0), 1, 32'h0000_2000, 32'h0);
        check("R7 store not signed", {31'b0, sign_ext}, 32'd0);
    endtask

    task automatic t_ldfmt();
        logic [31:0] d = 32'h8AF1_7C93;
        for (int ln = 0; ln < 4; ln++) begin
            logic [7:0] bv = d[8*ln +: 8];
            logic [15:0] hv = d[16*(ln/2) +: 16];
            // signed byte
            issue(enc_h(1, 1, 1, 0, 1, 1, 0, 4'h0, 4'h0), 1, 32'h0000_3000 + ln, 32'h0);
            rd_data = d; #1;
            check($sformatf("R9 sbyte lane %0d", ln), ld_data, {{24{bv[7]}}, bv});
            // unsigned byte
            issue(enc_w(1, 1, 1, 0, 1, 0, 12'h0), 0, 32'h0000_3000 + ln, 32'h0);
            rd_data = d; #1;
            check($sformatf("R9 ubyte lane %0d", ln), ld_data, {24'h0, bv});
            // signed halfword
            issue(enc_h(1, 1, 1, 0, 1, 1, 1, 4'h0, 4'h0), 1, 32'h0000_3000 + ln, 32'h0);
            rd_data = d; #1;
            check($sformatf("R9 shalf lane %0d", ln), ld_data, {{16{hv[15]}}, hv});
        end
        issue(enc_h(1, 1, 1, 0, 1, 0, 1, 4'h0, 4'h2), 1, 32'h0000_3000, 32'h0);
        rd_data = d; #1;
        check("R9 uhalf upper lane", ld_data, 32'h0000_8AF1);
        issue(enc_w(1, 1, 0, 0, 1, 0, 12'h0), 0, 32'h0000_3000, 32'h0);
        rd_data = d; #1;
        check("R9 word passthrough", ld_data, d);
    endtask

    task automatic t_idle();
        issue(enc_w(1, 1, 0, 1, 1, 0, 12'h040), 0, 32'h0000_5000, 32'h0);
        base_val = 32'hDEAD_0000; instr = enc_w(0, 0, 0, 0, 0, 0, 12'h001);
        @(negedge clk);
        check("R10 valid drops", {31'b0, out_valid}, 32'd0);
        check("R10 addr held", mem_addr, 32'h0000_5040);
        check("R10 wb_val held", wb_val, 32'h0000_5040);
    endtask

    initial begin
        t_reset();
        t_imm_pre();
        t_shifts();
        t_post();
        t_half();
        t_ldfmt();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule